// File: doc/BRIEF.md
# Asynchronous Flash Bus Write-Cycle Capture

This block sits at the edge of a clocked flash-controller core and watches the three active-low control pins of an asynchronous memory bus: chip select, write strobe and output enable. Each control line passes through a synchroniser and then a glitch filter. From the filtered levels the block works out when a bus write is under way. It takes the address at the moment the write opens and the data at the moment it closes, and then hands the command decoder one write pulse that lasts a single clock.

A write opens when the second of chip select and write strobe goes low while output enable is high. At that moment the address bus is sampled. The write closes when the first of those two lines goes high again, and at that moment the data bus is sampled. If output enable goes low in the middle, the cycle is dropped. After reset the block refuses every write until it has seen all three controls inactive at the same time. This keeps a bus that powers up with a write already asserted from delivering a false command. The block also produces the read-drive enable for the data pins. When this enable is low, the pins stay in high impedance.

Top module: `flashBusCapture`

## Requirements
- R1: A write pulse is produced only for a cycle in which chip select (`ceN`) and write strobe (`weN`) are both low while output enable (`oeN`) is high. If `oeN` goes low at any point in the cycle, or if `ceN` or `weN` is never low together with the other, no pulse is produced.
- R2: `wrAddr` takes the value of `addrIn` sampled when the later of `ceN` and `weN` goes low. An address present only at the earlier falling edge is not kept.
- R3: `wrData` takes the value of `dataIn` sampled when the earlier of `ceN` and `weN` goes high. Data placed on the bus after that edge is not kept.
- R4: A control level that lasts fewer than `FILT_LEN` consecutive clock samples is ignored. A short low pulse on `weN` starts no write, and a short high pulse inside a write does not split it. A level held for exactly `FILT_LEN` samples is accepted.
- R5: After reset no write pulse is produced until `ceN`, `weN` and `oeN` have all been seen high at the same time. A write strobe that was already low through reset, or any write made while only some of the lines have returned high, is discarded.
- R6: Each accepted write gives exactly one `wrPulse` high for exactly one clock. `wrAddr` and `wrData` hold their values between pulses.
- R7: `rdDrive` is high only while `ceN` and `oeN` are low and `weN` is high, after filtering. Otherwise it is low, which leaves the data pins in high impedance.
- R8: While `rstN` is low, `wrPulse` and `rdDrive` are 0, and `wrAddr` and `wrData` are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Asynchronous chip select, active low |
| weN | input | 1 | Asynchronous write strobe, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| addrIn | input | ADDR_W | Bus address |
| dataIn | input | DATA_W | Bus write data |
| wrPulse | output | 1 | One-clock strobe for an accepted write |
| wrAddr | output | ADDR_W | Address captured for the latest write |
| wrData | output | DATA_W | Data captured for the latest write |
| rdDrive | output | 1 | Data-pin drive enable for reads; low means high impedance |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `FILT_LEN` = 3, keeping the 19-bit address and 8-bit data widths. With a three-sample filter, a two-cycle strobe (which must be rejected) and a three-cycle strobe (which must be accepted) sit directly on either side of the glitch threshold. The short total latency also lets randomised falling and rising orders of chip select and write strobe run in a few hundred clocks each. Address and data are changed between the two falling edges and between the two rising edges, so capture at the wrong edge shows up as a wrong value.

// File: rtl/flashCapPkg.sv
package flashCapPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capAddr;   // write cycle opened: take address
    logic capData;   // write cycle closed: take data
    logic fire;      // issue the one-clock write pulse
  } capStrobeT;

  // Index of each control line inside the filtered vector
  localparam int LINE_CE = 0;
  localparam int LINE_WE = 1;
  localparam int LINE_OE = 2;
  localparam int NUM_LINES = 3;

endpackage

// File: rtl/flashCapSync.sv
module flashCapSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {stageQ[STAGES-2:0], din};
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/flashCapFilter.sv
module flashCapFilter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          levelQ;
  logic [CW-1:0] runCnt;

  // Output follows the input only after LEN consecutive disagreeing samples.
  // Reset level is 0 (asserted) so that the lock logic waits for real idles.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= 1'b0;
      runCnt <= '0;
    end else if (din == levelQ) begin
      runCnt <= '0;
    end else if (runCnt == LAST) begin
      levelQ <= din;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign dout = levelQ;

endmodule

// File: rtl/flashCapCtrl.sv
module flashCapCtrl
  import flashCapPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 weN,
  input  logic                 oeN,
  output logic [NUM_LINES-1:0] filtN,
  output logic                 locked,
  output capStrobeT            strobes,
  output logic                 rdDrive
);

  logic [NUM_LINES-1:0] rawN;
  logic [NUM_LINES-1:0] syncN;

  assign rawN[LINE_CE] = ceN;
  assign rawN[LINE_WE] = weN;
  assign rawN[LINE_OE] = oeN;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    flashCapSync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawN[i]),
      .dout(syncN[i])
    );
    flashCapFilter #(.LEN(FILT_LEN)) u_filt (
      .clk (clk),
      .rstN(rstN),
      .din (syncN[i]),
      .dout(filtN[i])
    );
  end

  logic ceF, weF, oeF;
  assign ceF = filtN[LINE_CE];
  assign weF = filtN[LINE_WE];
  assign oeF = filtN[LINE_OE];

  logic wrSel, prevSel, armed, selRise, closeOk;

  assign wrSel   = !ceF && !weF && oeF && !locked;
  assign selRise = wrSel && !prevSel;
  // closed by the first of select/strobe rising, output enable still high
  assign closeOk = armed && (ceF || weF) && oeF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked  <= 1'b1;
      prevSel <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (&filtN) locked <= 1'b0;
      prevSel <= wrSel;
      if (selRise)             armed <= 1'b1;
      else if (armed && !wrSel) armed <= 1'b0;
    end
  end

  assign strobes.capAddr = selRise;
  assign strobes.capData = closeOk;
  assign strobes.fire    = closeOk;

  assign rdDrive = !ceF && !oeF && weF;

endmodule

// File: rtl/flashCapPath.sv
module flashCapPath
  import flashCapPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobeT         strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrPulse,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr  <= '0;
      wrData  <= '0;
      wrPulse <= 1'b0;
    end else begin
      if (strobes.capAddr) wrAddr <= addrIn;
      if (strobes.capData) wrData <= dataIn;
      wrPulse <= strobes.fire;
    end
  end

endmodule

// File: rtl/flashBusCapture.sv
module flashBusCapture
  import flashCapPkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrPulse,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              rdDrive
);

  logic [NUM_LINES-1:0] filtN;
  logic                 locked;
  capStrobeT            strobes;

  flashCapCtrl #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .weN    (weN),
    .oeN    (oeN),
    .filtN  (filtN),
    .locked (locked),
    .strobes(strobes),
    .rdDrive(rdDrive)
  );

  flashCapPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .addrIn (addrIn),
    .dataIn (dataIn),
    .wrPulse(wrPulse),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

endmodule

// File: rtl/flashBusCaptureChk.sv
module flashBusCaptureChk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrPulse,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              capAddr,
  input logic              capData,
  input logic              oeF,
  input logic              locked
);

  // R1: a pulse follows a cycle in which output enable was high
  a_r1_oe_high_at_fire: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |-> $past(oeF));

  // R2: the address register moves only on an address-capture strobe
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(capAddr) |-> $stable(wrAddr));

  // R3: the data register moves only on a data-capture strobe
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(capData) |-> $stable(wrData));

  // R5: no pulse while the power-up lock is set
  a_r5_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !wrPulse);

  // R6: pulse lasts one clock
  a_r6_single_clock: assert property (@(posedge clk) disable iff (!rstN)
    wrPulse |=> !wrPulse);

endmodule

bind flashBusCapture flashBusCaptureChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrPulse(wrPulse),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .capAddr(strobes.capAddr),
  .capData(strobes.capData),
  .oeF    (filtN[2]),
  .locked (locked)
);

// File: tb/flashBusCapture_tb.sv
`timescale 1ns/1ps
module flashBusCapture_tb;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN, weN, oeN;
  logic [AW-1:0] addrIn;
  logic [DW-1:0] dataIn;
  logic wrPulse, rdDrive;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  int checkCnt = 0;
  int failCnt = 0;
  int pulseCnt = 0;
  int wideCnt = 0;
  logic prevPulse = 1'b0;
  logic [AW-1:0] seenAddr;
  logic [DW-1:0] seenData;

  always #2.5 clk = ~clk;

  flashBusCapture #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .FILT_LEN(3)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn),
    .wrPulse(wrPulse), .wrAddr(wrAddr), .wrData(wrData), .rdDrive(rdDrive)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wrPulse) begin
        pulseCnt <= pulseCnt + 1;
        seenAddr <= wrAddr;
        seenData <= wrData;
        if (prevPulse) wideCnt <= wideCnt + 1;
      end
      prevPulse <= wrPulse;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLine(input bit useWe, input logic v);
    if (useWe) weN = v; else ceN = v;
  endtask

  // expected values from the requirements
  function automatic logic [AW-1:0] laterFallAddr(input bit weFallsFirst,
      input logic [AW-1:0] addrAtWe, input logic [AW-1:0] addrAtCe);
    return weFallsFirst ? addrAtCe : addrAtWe;
  endfunction

  function automatic logic [DW-1:0] firstRiseData(input bit weRisesFirst,
      input logic [DW-1:0] dataAtWe, input logic [DW-1:0] dataAtCe);
    return weRisesFirst ? dataAtWe : dataAtCe;
  endfunction

  // one write with controllable edge order; abortOe drops output enable midway
  task automatic doWrite(input bit weFallsFirst, input bit weRisesFirst, input bit abortOe,
      input logic [AW-1:0] a0, input logic [AW-1:0] a1,
      input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    int startCnt;
    logic [AW-1:0] addrAtWe, addrAtCe;
    logic [DW-1:0] dataAtWe, dataAtCe;
    startCnt = pulseCnt;
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    waitCyc(HOLD);
    addrIn = a0;
    setLine(weFallsFirst, 1'b0);
    if (weFallsFirst) addrAtWe = a0; else addrAtCe = a0;
    waitCyc(HOLD);
    addrIn = a1;
    setLine(!weFallsFirst, 1'b0);
    if (weFallsFirst) addrAtCe = a1; else addrAtWe = a1;
    waitCyc(HOLD);
    if (abortOe) begin
      oeN = 1'b0;
      waitCyc(HOLD);
    end
    dataIn = d0;
    waitCyc(2);
    setLine(weRisesFirst, 1'b1);
    if (weRisesFirst) dataAtWe = d0; else dataAtCe = d0;
    waitCyc(HOLD);
    dataIn = d1;
    addrIn = ~a1;
    setLine(!weRisesFirst, 1'b1);
    if (weRisesFirst) dataAtCe = d1; else dataAtWe = d1;
    waitCyc(HOLD + 2);
    oeN = 1'b1;
    waitCyc(HOLD);
    if (abortOe) begin
      check(pulseCnt == startCnt, "R1 oe low aborts write", pulseCnt - startCnt, 0);
    end else begin
      check(pulseCnt == startCnt + 1, "R6 one pulse per write", pulseCnt - startCnt, 1);
      check(seenAddr == laterFallAddr(weFallsFirst, addrAtWe, addrAtCe),
            "R2 address at later fall", seenAddr,
            laterFallAddr(weFallsFirst, addrAtWe, addrAtCe));
      check(seenData == firstRiseData(weRisesFirst, dataAtWe, dataAtCe),
            "R3 data at first rise", seenData,
            firstRiseData(weRisesFirst, dataAtWe, dataAtCe));
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
  endtask

  initial begin
    #1_000_000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int startCnt;
    void'($urandom(32'd20240611));
    // power-up with a write already asserted
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1;
    addrIn = 19'h12345; dataIn = 8'hA5;
    waitCyc(4);
    // R8: reset state
    check(wrPulse == 1'b0, "R8 reset wrPulse", wrPulse, 0);
    check(rdDrive == 1'b0, "R8 reset rdDrive", rdDrive, 0);
    check(wrAddr == '0, "R8 reset wrAddr", wrAddr, 0);
    check(wrData == '0, "R8 reset wrData", wrData, 0);
    rstN = 1'b1;
    waitCyc(HOLD);
    // R5: strobe released after reset is not a command
    weN = 1'b1;
    waitCyc(HOLD);
    check(pulseCnt == 0, "R5 power-up strobe ignored", pulseCnt, 0);
    // R5: lock still held while chip select stays low
    weN = 1'b0; waitCyc(HOLD); weN = 1'b1; waitCyc(HOLD);
    check(pulseCnt == 0, "R5 lock held until all idle", pulseCnt, 0);
    ceN = 1'b1;
    waitCyc(HOLD);
    doWrite(1'b1, 1'b1, 1'b0, 19'h00100, 19'h7ABCD, 8'h3C, 8'hC3);

    // R1: chip select high throughout
    startCnt = pulseCnt;
    ceN = 1'b1; oeN = 1'b1;
    weN = 1'b0; waitCyc(HOLD); weN = 1'b1; waitCyc(HOLD);
    check(pulseCnt == startCnt, "R1 chip select high inhibits", pulseCnt - startCnt, 0);
    // R1: output enable low throughout
    oeN = 1'b0; ceN = 1'b0; weN = 1'b0; waitCyc(HOLD);
    weN = 1'b1; ceN = 1'b1; waitCyc(HOLD); oeN = 1'b1; waitCyc(HOLD);
    check(pulseCnt == startCnt, "R1 oe low inhibits", pulseCnt - startCnt, 0);

    // R4: two-cycle strobe glitch rejected
    ceN = 1'b0; waitCyc(HOLD);
    weN = 1'b0; waitCyc(2); weN = 1'b1; waitCyc(HOLD);
    ceN = 1'b1; waitCyc(HOLD);
    check(pulseCnt == startCnt, "R4 short strobe ignored", pulseCnt - startCnt, 0);
    // R4: exactly FILT_LEN cycles accepted
    addrIn = 19'h05A5A; dataIn = 8'h77;
    ceN = 1'b0; waitCyc(HOLD);
    weN = 1'b0; waitCyc(3); weN = 1'b1; waitCyc(HOLD);
    ceN = 1'b1; waitCyc(HOLD);
    check(pulseCnt == startCnt + 1, "R4 threshold strobe accepted", pulseCnt - startCnt, 1);
    check(seenAddr == 19'h05A5A, "R4 threshold write address", seenAddr, 19'h05A5A);
    // R4: short high glitch inside a write does not split it
    startCnt = pulseCnt;
    addrIn = 19'h01111; dataIn = 8'h5E;
    ceN = 1'b0; waitCyc(HOLD); weN = 1'b0; waitCyc(HOLD);
    addrIn = 19'h02222;
    weN = 1'b1; waitCyc(2); weN = 1'b0; waitCyc(HOLD);
    weN = 1'b1; waitCyc(HOLD); ceN = 1'b1; waitCyc(HOLD);
    check(pulseCnt == startCnt + 1, "R4 high glitch keeps one write", pulseCnt - startCnt, 1);
    check(seenAddr == 19'h01111, "R4 glitch did not reopen cycle", seenAddr, 19'h01111);

    // R7: read drive
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; waitCyc(HOLD);
    check(rdDrive == 1'b1, "R7 read drives", rdDrive, 1);
    oeN = 1'b1; waitCyc(HOLD);
    check(rdDrive == 1'b0, "R7 oe high floats", rdDrive, 0);
    ceN = 1'b1; oeN = 1'b0; waitCyc(HOLD);
    check(rdDrive == 1'b0, "R7 ce high floats", rdDrive, 0);
    ceN = 1'b0; weN = 1'b0; waitCyc(HOLD);
    check(rdDrive == 1'b0, "R7 strobe low floats", rdDrive, 0);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1; waitCyc(HOLD);

    // directed edge orders, then random mix
    doWrite(1'b0, 1'b0, 1'b0, 19'h00001, 19'h7FFFF, 8'h00, 8'hFF);
    doWrite(1'b1, 1'b0, 1'b0, 19'h40000, 19'h00000, 8'hFF, 8'h00);
    doWrite(1'b0, 1'b1, 1'b0, 19'h2AAAA, 19'h55555, 8'h81, 8'h18);
    doWrite(1'b1, 1'b1, 1'b1, 19'h00010, 19'h00020, 8'h11, 8'h22);
    for (int i = 0; i < 40; i++) begin
      doWrite(1'($urandom), 1'($urandom), ($urandom % 4) == 0,
              AW'($urandom), AW'($urandom), DW'($urandom), DW'($urandom));
    end

    check(wideCnt == 0, "R6 pulse width one clock", wideCnt, 0);
    summary();
    $finish;
  end

endmodule